// File: doc/BRIEF.md
# CSR Request Legality Gate

This block sits at the front of a TL-UL device port that serves a small bank of 32-bit control and status registers. Each A-channel request carries an opcode, a size, an address, a byte mask, write data, a source tag and an instruction-type flag. The gate checks the request against the bus protocol rules and the register map rules. A legal request goes to a simple register backend as a one-cycle strobe. An illegal request never reaches the backend. It is answered on the D channel with the error bit set.

The register map is set by parameters: a list of word offsets and, for each one, how many low bytes the register actually implements (1 to 4). Only one transaction may be in flight. A new request is held off until the D-channel response has been taken. The backend supplies read data in the same cycle as the strobe. The response is registered and held until the receiver is ready.

Top module: `csr_req_gate`

## Requirements
- R1: Only three opcode values are legal: PutFullData (3'd0), PutPartialData (3'd1) and Get (3'd4). Any other value gets an error response.
- R2: A size of 3 is an error. A size of 1 with address bit 0 set is an error. A size of 2 with address bits [1:0] not zero is an error.
- R3: Each size selects a set of byte lanes. Size 0 selects lane addr[1:0]. Size 1 selects lanes 1:0 when addr[1] is 0 and lanes 3:2 when it is 1. Size 2 selects all four lanes. A mask bit set outside the selected lanes is an error.
- R4: A PutFullData request must set every mask bit inside its selected lanes, or it is an error.
- R5: A request whose word address (address with bits [1:0] cleared) is not one of the mapped offsets is an error, for reads and writes alike.
- R6: A write with address bits [1:0] not zero is an error. A write is also an error unless mask bits [W-1:0] are all set, where W is the byte width of the target register. Extra mask bits above W are allowed.
- R7: A write with the instruction-type flag set is an error. A read with the flag set is legal.
- R8: A legal read returns the full 32-bit register word for any legal mask. The response opcode is AccessAckData (3'd1) for Get and AccessAck (3'd0) for every other request. The response echoes the request's size and source.
- R9: An error response has d_error high and data all ones. It causes no backend request, so no register changes.
- R10: Only one transaction is outstanding at a time. a_ready is low while a response is pending. A pending response stays valid and unchanged until d_ready is high.
- R11: A legal write produces exactly one backend strobe, in the cycle the request is accepted. The strobe carries the register index, the write data and the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_valid_i | input | 1 | Request valid |
| a_ready_o | output | 1 | Request accepted when high together with valid |
| a_opcode_i | input | 3 | Request opcode |
| a_size_i | input | 2 | Log2 of transfer bytes |
| a_address_i | input | AW | Byte address |
| a_mask_i | input | 4 | Byte mask |
| a_data_i | input | 32 | Write data |
| a_source_i | input | SW | Source tag |
| a_instr_i | input | 1 | Instruction-type flag |
| d_valid_o | output | 1 | Response valid |
| d_ready_i | input | 1 | Response taken |
| d_opcode_o | output | 3 | Response opcode |
| d_size_o | output | 2 | Echoed size |
| d_source_o | output | SW | Echoed source |
| d_data_o | output | 32 | Read data, all ones on error |
| d_error_o | output | 1 | Error flag |
| be_req_o | output | 1 | Backend access strobe |
| be_we_o | output | 1 | Backend write select |
| be_idx_o | output | IW | Register index |
| be_wdata_o | output | 32 | Backend write data |
| be_wmask_o | output | 4 | Backend byte mask |
| be_rdata_i | input | 32 | Backend read data for be_idx_o |

## Verification
The bench sends legal reads with full, single-lane and offset masks. It sends legal writes that exactly cover a register's width or go past it. These show that the legal path reaches the backend and returns whole words. It then sends one case for each rule, each built to break that rule alone where possible: bad opcodes, an oversized or misaligned size, mask bits outside the selected lanes, a PutFullData with a missing lane, an unmapped word, a write at a non-zero byte offset, a write that covers too few bytes, and an instruction-flagged write. Reads after the bad writes, plus a count of backend strobes, show that no register was touched. A held-off response checks the single-outstanding rule: a_ready must stay low and the response must not change. Back-to-back reads of the same address check that both answers come out in order.

// File: rtl/csrgate_pkg.sv
package csrgate_pkg;

   localparam int unsigned WORD_W  = 32;
   localparam int unsigned LANES   = WORD_W / 8;

   localparam logic [2:0] OP_PUT_FULL = 3'd0;
   localparam logic [2:0] OP_PUT_PART = 3'd1;
   localparam logic [2:0] OP_GET      = 3'd4;

   typedef enum logic [2:0] {
      RSP_ACK      = 3'd0,
      RSP_ACK_DATA = 3'd1
   } rsp_op_e;

   // byte lanes selected by a transfer of the given size at the given low address
   function automatic logic [LANES-1:0] size_lanes(input logic [1:0] size,
                                                   input logic [1:0] lo);
      logic [LANES-1:0] l;
      case (size)
         2'd0:    l = 4'b0001 << lo;
         2'd1:    l = lo[1] ? 4'b1100 : 4'b0011;
         2'd2:    l = 4'b1111;
         default: l = 4'b0000;
      endcase
      return l;
   endfunction

   // lanes a register of the given byte width implements
   function automatic logic [LANES-1:0] width_lanes(input logic [2:0] bytes);
      logic [LANES-1:0] l;
      case (bytes)
         3'd1:    l = 4'b0001;
         3'd2:    l = 4'b0011;
         3'd3:    l = 4'b0111;
         default: l = 4'b1111;
      endcase
      return l;
   endfunction

endpackage

// File: rtl/csrgate_proto_chk.sv
module csrgate_proto_chk
   import csrgate_pkg::*;
(
   input  logic [2:0]       opcode_i,
   input  logic [1:0]       size_i,
   input  logic [1:0]       addr_lo_i,
   input  logic [LANES-1:0] mask_i,
   output logic             is_write_o,
   output logic             is_get_o,
   output logic             err_o
);

   logic [LANES-1:0] lanes;
   logic             op_bad, size_bad, align_bad, mask_out, full_gap;

   always_comb begin
      is_get_o   = (opcode_i == OP_GET);
      is_write_o = (opcode_i == OP_PUT_FULL) || (opcode_i == OP_PUT_PART);
      op_bad     = !(is_get_o || is_write_o);
      lanes      = size_lanes(size_i, addr_lo_i);
      size_bad   = (size_i == 2'd3);
      align_bad  = ((size_i == 2'd1) && addr_lo_i[0]) ||
                   ((size_i == 2'd2) && (addr_lo_i != 2'b00));
      mask_out   = |(mask_i & ~lanes);
      full_gap   = (opcode_i == OP_PUT_FULL) && ((mask_i & lanes) != lanes);
      err_o      = op_bad | size_bad | align_bad | mask_out | full_gap;
   end

endmodule

// File: rtl/csrgate_map_dec.sv
module csrgate_map_dec
   import csrgate_pkg::*;
#(
   parameter int unsigned             AW        = 12,
   parameter int unsigned             NUM_REGS  = 4,
   parameter int unsigned             IW        = 2,
   parameter logic [NUM_REGS*AW-1:0]  REG_OFFS  = '0,
   parameter logic [NUM_REGS*3-1:0]   REG_BYTES = '0
) (
   input  logic [AW-1:0]    addr_i,
   output logic             hit_o,
   output logic [IW-1:0]    idx_o,
   output logic [LANES-1:0] need_o
);

   logic [NUM_REGS-1:0] hv;
   logic [AW-1:0]       word_addr;

   assign word_addr = {addr_i[AW-1:2], 2'b00};

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
      initial begin
         a_cfg_width: assert (REG_BYTES[g*3 +: 3] >= 3'd1 && REG_BYTES[g*3 +: 3] <= 3'd4)
            else $error("register %0d byte width out of range", g);
         a_cfg_align: assert (REG_OFFS[g*AW +: 2] == 2'b00)
            else $error("register %0d offset not word aligned", g);
      end
      assign hv[g] = (word_addr == REG_OFFS[g*AW +: AW]);
   end

   // lowest index wins if two offsets collide
   always_comb begin
      hit_o  = 1'b0;
      idx_o  = '0;
      need_o = 4'b1111;
      for (int i = NUM_REGS - 1; i >= 0; i--) begin
         if (hv[i]) begin
            hit_o  = 1'b1;
            idx_o  = IW'(i);
            need_o = width_lanes(REG_BYTES[i*3 +: 3]);
         end
      end
   end

endmodule

// File: rtl/csrgate_rsp_reg.sv
module csrgate_rsp_reg
   import csrgate_pkg::*;
#(
   parameter int unsigned SW = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_i,
   input  logic              ld_err_i,
   input  rsp_op_e           ld_op_i,
   input  logic [1:0]        ld_size_i,
   input  logic [SW-1:0]     ld_src_i,
   input  logic [WORD_W-1:0] ld_data_i,
   input  logic              d_ready_i,
   output logic              busy_o,
   output logic [2:0]        d_opcode_o,
   output logic [1:0]        d_size_o,
   output logic [SW-1:0]     d_source_o,
   output logic [WORD_W-1:0] d_data_o,
   output logic              d_error_o
);

   rsp_op_e op_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_o     <= 1'b0;
         op_q       <= RSP_ACK;
         d_size_o   <= '0;
         d_source_o <= '0;
         d_data_o   <= '0;
         d_error_o  <= 1'b0;
      end else if (load_i) begin
         busy_o     <= 1'b1;
         op_q       <= ld_op_i;
         d_size_o   <= ld_size_i;
         d_source_o <= ld_src_i;
         d_data_o   <= ld_data_i;
         d_error_o  <= ld_err_i;
      end else if (d_ready_i) begin
         busy_o     <= 1'b0;
      end
   end

   assign d_opcode_o = op_q;

   a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o && !d_ready_i |=> busy_o && $stable(d_data_o) && $stable(d_error_o)
                               && $stable(d_source_o));

   a_r9_err_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o && d_error_o |-> d_data_o == '1);

endmodule

// File: rtl/csr_req_gate.sv
module csr_req_gate
   import csrgate_pkg::*;
#(
   parameter int unsigned            AW        = 12,
   parameter int unsigned            SW        = 8,
   parameter int unsigned            NUM_REGS  = 4,
   parameter logic [NUM_REGS*AW-1:0] REG_OFFS  = {12'h00C, 12'h008, 12'h004, 12'h000},
   parameter logic [NUM_REGS*3-1:0]  REG_BYTES = {3'd1, 3'd4, 3'd2, 3'd4},
   localparam int unsigned           IW        = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              a_valid_i,
   output logic              a_ready_o,
   input  logic [2:0]        a_opcode_i,
   input  logic [1:0]        a_size_i,
   input  logic [AW-1:0]     a_address_i,
   input  logic [3:0]        a_mask_i,
   input  logic [31:0]       a_data_i,
   input  logic [SW-1:0]     a_source_i,
   input  logic              a_instr_i,
   output logic              d_valid_o,
   input  logic              d_ready_i,
   output logic [2:0]        d_opcode_o,
   output logic [1:0]        d_size_o,
   output logic [SW-1:0]     d_source_o,
   output logic [31:0]       d_data_o,
   output logic              d_error_o,
   output logic              be_req_o,
   output logic              be_we_o,
   output logic [IW-1:0]     be_idx_o,
   output logic [31:0]       be_wdata_o,
   output logic [3:0]        be_wmask_o,
   input  logic [31:0]       be_rdata_i
);

   initial begin
      a_cfg_aw: assert (AW >= 3) else $error("address width too small");
      a_cfg_sw: assert (SW >= 1) else $error("source width must be nonzero");
      a_cfg_n:  assert (NUM_REGS >= 1) else $error("need at least one register");
   end

   logic             is_write, is_get, proto_err;
   logic             hit;
   logic [LANES-1:0] need;
   logic             dev_err, err, acc, busy;
   logic [WORD_W-1:0] rsp_data;

   csrgate_proto_chk u_proto (
      .opcode_i   (a_opcode_i),
      .size_i     (a_size_i),
      .addr_lo_i  (a_address_i[1:0]),
      .mask_i     (a_mask_i),
      .is_write_o (is_write),
      .is_get_o   (is_get),
      .err_o      (proto_err)
   );

   csrgate_map_dec #(
      .AW        (AW),
      .NUM_REGS  (NUM_REGS),
      .IW        (IW),
      .REG_OFFS  (REG_OFFS),
      .REG_BYTES (REG_BYTES)
   ) u_map (
      .addr_i (a_address_i),
      .hit_o  (hit),
      .idx_o  (be_idx_o),
      .need_o (need)
   );

   always_comb begin
      dev_err = !hit;
      if (is_write) begin
         dev_err = dev_err | (a_address_i[1:0] != 2'b00)
                           | ((a_mask_i & need) != need)
                           | a_instr_i;
      end
      err      = proto_err | dev_err;
      acc      = a_valid_i & a_ready_o;
      be_req_o = acc & ~err;
      be_we_o  = is_write;
      be_wdata_o = a_data_i;
      be_wmask_o = a_mask_i;
      if (err)           rsp_data = '1;
      else if (is_write) rsp_data = '0;
      else               rsp_data = be_rdata_i;
   end

   csrgate_rsp_reg #(.SW(SW)) u_rsp (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (acc),
      .ld_err_i   (err),
      .ld_op_i    (is_get ? RSP_ACK_DATA : RSP_ACK),
      .ld_size_i  (a_size_i),
      .ld_src_i   (a_source_i),
      .ld_data_i  (rsp_data),
      .d_ready_i  (d_ready_i),
      .busy_o     (busy),
      .d_opcode_o (d_opcode_o),
      .d_size_o   (d_size_o),
      .d_source_o (d_source_o),
      .d_data_o   (d_data_o),
      .d_error_o  (d_error_o)
   );

   assign a_ready_o = ~busy;
   assign d_valid_o = busy;

   a_r2_big_size: assert property (@(posedge clk_i) disable iff (!rst_ni)
      a_valid_i && a_ready_o && a_size_i == 2'd3 |=> d_valid_o && d_error_o);

   a_r7_instr_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      a_valid_i && a_ready_o && a_instr_i &&
      (a_opcode_i == OP_PUT_FULL || a_opcode_i == OP_PUT_PART) |=> d_error_o);

   a_r8_rsp_opcode: assert property (@(posedge clk_i) disable iff (!rst_ni)
      a_valid_i && a_ready_o |=>
      d_opcode_o == (($past(a_opcode_i) == OP_GET) ? 3'd1 : 3'd0));

   a_r10_one_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
      be_req_o |-> !d_valid_o);

   a_r11_write_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
      be_req_o && be_we_o |-> a_address_i[1:0] == 2'b00);

endmodule

// File: tb/csr_req_gate_tb.sv
module csr_req_gate_tb;

   localparam int AW = 12;
   localparam int SW = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        a_valid = 1'b0;
   logic        a_ready;
   logic [2:0]  a_opcode = '0;
   logic [1:0]  a_size = '0;
   logic [AW-1:0] a_address = '0;
   logic [3:0]  a_mask = '0;
   logic [31:0] a_data = '0;
   logic [SW-1:0] a_source = '0;
   logic        a_instr = 1'b0;
   logic        d_valid, d_ready = 1'b0;
   logic [2:0]  d_opcode;
   logic [1:0]  d_size;
   logic [SW-1:0] d_source;
   logic [31:0] d_data;
   logic        d_error;
   logic        be_req, be_we;
   logic [1:0]  be_idx;
   logic [31:0] be_wdata, be_rdata;
   logic [3:0]  be_wmask;

   always #10 clk = ~clk;

   csr_req_gate u_dut (
      .clk_i(clk), .rst_ni(rst_n),
      .a_valid_i(a_valid), .a_ready_o(a_ready), .a_opcode_i(a_opcode),
      .a_size_i(a_size), .a_address_i(a_address), .a_mask_i(a_mask),
      .a_data_i(a_data), .a_source_i(a_source), .a_instr_i(a_instr),
      .d_valid_o(d_valid), .d_ready_i(d_ready), .d_opcode_o(d_opcode),
      .d_size_o(d_size), .d_source_o(d_source), .d_data_o(d_data),
      .d_error_o(d_error), .be_req_o(be_req), .be_we_o(be_we),
      .be_idx_o(be_idx), .be_wdata_o(be_wdata), .be_wmask_o(be_wmask),
      .be_rdata_i(be_rdata)
   );

   // backend register model driven only through the strobe
   logic [31:0] bk [4];
   logic [31:0] sh [4];
   int          wr_count = 0;
   assign be_rdata = bk[be_idx];

   initial for (int i = 0; i < 4; i++) begin
      bk[i] = 32'hC0DE_0000 | i;
      sh[i] = 32'hC0DE_0000 | i;
   end

   always @(posedge clk) if (be_req && be_we) begin
      wr_count <= wr_count + 1;
      for (int b = 0; b < 4; b++) if (be_wmask[b]) bk[be_idx][8*b +: 8] <= be_wdata[8*b +: 8];
   end

   typedef struct {
      string       tag;
      logic        err;
      logic [2:0]  op;
      logic [1:0]  size;
      logic [7:0]  src;
      logic [31:0] data;
   } exp_t;

   exp_t q[$];
   int   n_run = 0, n_fail = 0;
   int   cyc = 0;
   bit   stall = 0;
   logic [7:0] src_cnt = 8'h10;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: drives d_ready and compares each handshake at the negedge before it
   always @(negedge clk) begin
      bit r;
      cyc++;
      r = !stall && (cyc % 3 != 2);
      d_ready = r;
      if (rst_n && d_valid && r) begin
         if (q.size() == 0) chk(0, "R10 unexpected response", {32'h0, d_data}, 64'h0);
         else begin
            exp_t e;
            e = q.pop_front();
            chk(d_error == e.err && d_data == e.data && d_opcode == e.op &&
                d_size == e.size && d_source == e.src, e.tag,
                {d_error, d_opcode, d_size, d_source, 18'h0, d_data},
                {e.err, e.op, e.size, e.src, 18'h0, e.data});
         end
      end
   end

   // driver: called at a negedge, returns at the negedge after acceptance
   task automatic req(input logic [2:0] op, input logic [1:0] sz, input logic [11:0] ad,
                      input logic [3:0] mk, input logic [31:0] dt, input bit ins,
                      input bit exp_err, input string tag);
      exp_t e;
      bit wr;
      wr = (op == 3'd0) || (op == 3'd1);
      e.tag = tag; e.err = exp_err; e.op = (op == 3'd4) ? 3'd1 : 3'd0;
      e.size = sz; e.src = src_cnt;
      if (exp_err) e.data = '1;
      else if (wr) begin
         e.data = '0;
         for (int b = 0; b < 4; b++) if (mk[b]) sh[ad[3:2]][8*b +: 8] = dt[8*b +: 8];
      end else e.data = sh[ad[3:2]];
      q.push_back(e);
      a_opcode = op; a_size = sz; a_address = ad; a_mask = mk;
      a_data = dt; a_instr = ins; a_source = src_cnt; a_valid = 1'b1;
      forever begin
         if (a_ready) begin @(posedge clk); break; end
         @(negedge clk);
      end
      @(negedge clk);
      a_valid = 1'b0;
      src_cnt++;
   endtask

   task automatic drain();
      for (int i = 0; i < 200 && (q.size() != 0 || d_valid); i++) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      chk(0, "watchdog expired", 64'h0, 64'h1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int wc;
      logic [31:0] held;
      repeat (3) @(negedge clk);
      chk(d_valid == 0 && a_ready == 1 && be_req == 0, "R10 reset state",
          {d_valid, a_ready, be_req}, 64'h2);
      rst_n = 1'b1;
      @(negedge clk);

      // legal reads and writes
      req(3'd4, 2'd2, 12'h000, 4'hF, 0, 0, 0, "R8 full read reg0");
      req(3'd4, 2'd0, 12'h005, 4'h2, 0, 0, 0, "R8 byte read returns word");
      req(3'd0, 2'd2, 12'h000, 4'hF, 32'h1122_3344, 0, 0, "R11 putfull write reg0");
      req(3'd4, 2'd1, 12'h002, 4'hC, 0, 0, 0, "R11 readback reg0");
      req(3'd1, 2'd2, 12'h004, 4'h3, 32'h5555_BEEF, 0, 0, "R6 write covering 2-byte reg");
      req(3'd4, 2'd2, 12'h004, 4'hF, 0, 0, 0, "R6 readback reg1");
      req(3'd1, 2'd0, 12'h00C, 4'h1, 32'h0000_005A, 0, 0, "R6 byte write 1-byte reg");
      req(3'd4, 2'd2, 12'h00C, 4'hF, 0, 0, 0, "R6 readback reg3");
      req(3'd4, 2'd2, 12'h008, 4'hF, 0, 1, 0, "R7 instr-flagged read legal");
      drain();

      // illegal requests: none may write
      wc = wr_count;
      req(3'd2, 2'd2, 12'h000, 4'hF, 32'hDEAD_0001, 0, 1, "R1 opcode 2");
      req(3'd3, 2'd2, 12'h000, 4'hF, 32'hDEAD_0002, 0, 1, "R1 opcode 3");
      req(3'd5, 2'd2, 12'h000, 4'hF, 0, 0, 1, "R1 opcode 5");
      req(3'd4, 2'd3, 12'h000, 4'hF, 0, 0, 1, "R2 size 3");
      req(3'd4, 2'd1, 12'h001, 4'h2, 0, 0, 1, "R2 size1 misaligned");
      req(3'd1, 2'd2, 12'h002, 4'hC, 32'hDEAD_0003, 0, 1, "R2 size2 misaligned write");
      req(3'd4, 2'd0, 12'h000, 4'h2, 0, 0, 1, "R3 mask off lane");
      req(3'd4, 2'd1, 12'h006, 4'h3, 0, 0, 1, "R3 mask low lanes at upper half");
      req(3'd0, 2'd1, 12'h00C, 4'h1, 32'hDEAD_0004, 0, 1, "R4 putfull gap");
      req(3'd4, 2'd2, 12'h040, 4'hF, 0, 0, 1, "R5 unmapped read");
      req(3'd0, 2'd2, 12'h010, 4'hF, 32'hDEAD_0005, 0, 1, "R5 unmapped write");
      req(3'd1, 2'd0, 12'h009, 4'h2, 32'hDEAD_0006, 0, 1, "R6 write nonzero offset");
      req(3'd1, 2'd2, 12'h004, 4'h1, 32'hDEAD_0007, 0, 1, "R6 write short of width");
      req(3'd0, 2'd2, 12'h008, 4'hF, 32'hDEAD_0008, 1, 1, "R7 instr-flagged write");
      drain();
      chk(wr_count == wc, "R9 no backend write on errors", wr_count, wc);
      req(3'd4, 2'd2, 12'h000, 4'hF, 0, 0, 0, "R9 reg0 untouched");
      req(3'd4, 2'd2, 12'h004, 4'hF, 0, 0, 0, "R9 reg1 untouched");
      req(3'd4, 2'd2, 12'h008, 4'hF, 0, 0, 0, "R9 reg2 untouched");
      req(3'd4, 2'd2, 12'h00C, 4'hF, 0, 0, 0, "R9 reg3 untouched");
      drain();
      wc = wr_count;
      req(3'd0, 2'd2, 12'h008, 4'hF, 32'hA0B0_C0D0, 0, 0, "R11 single write");
      drain();
      chk(wr_count == wc + 1, "R11 exactly one strobe", wr_count, wc + 1);

      // single outstanding: held response blocks a second request
      stall = 1;
      @(negedge clk);
      @(negedge clk);
      req(3'd4, 2'd2, 12'h008, 4'hF, 0, 0, 0, "R10 stalled read");
      held = d_data;
      a_opcode = 3'd4; a_size = 2'd2; a_address = 12'h008; a_mask = 4'hF;
      a_instr = 0; a_source = src_cnt; a_valid = 1'b1;
      for (int i = 0; i < 3; i++) begin
         chk(d_valid && !a_ready && d_data == held, "R10 blocked while pending",
             {d_valid, a_ready, d_data}, {2'b10, held});
         @(negedge clk);
      end
      a_valid = 1'b0;
      stall = 0;
      req(3'd4, 2'd2, 12'h008, 4'hF, 0, 0, 0, "R10 back-to-back same address 1");
      req(3'd4, 2'd2, 12'h008, 4'hF, 0, 0, 0, "R10 back-to-back same address 2");
      drain();
      chk(q.size() == 0 && !d_valid, "R10 all responses returned", q.size(), 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule